// File: doc/BRIEF.md
# Markov Transition Sampler

This block performs one step of a random walk over a square matrix. The rows of the matrix are held in a small on-chip table. Each row is stored as running totals of the absolute values of its entries, together with one sign bit per entry. The matrix being walked is the identity minus an input matrix, and software prepares this table before the first step.

For each step, the caller presents the current state and pulses `start`. The block then draws a random number from an internal linear-feedback generator and scales it by the current row's weight, which is the row's sum of absolute values. It scans the row one column per cycle until it finds the first running total that exceeds the scaled number. A column is therefore chosen with probability equal to its absolute value divided by the row weight.

The block reports three results: the chosen column as the next state, the sign of the entry it crossed, and the weight of the row it lands on. The caller can use these to update a chain weight.

Top module: `markov_step_sampler`

## Requirements
- R1: After a synchronous active-low reset, `done`, `next_state`, `next_neg` and `next_weight` are all 0, and the random generator holds 32'h1D87_2B41.
- R2: A cycle with `tbl_we` high stores `tbl_cum` as the running total of absolute values up to and including column `tbl_col` of row `tbl_row`, and stores `tbl_neg` as that entry's sign (1 means negative). The weight of a row is the value stored in its last column, N_STATES-1.
- R3: On an accepted start, the random draw r is bits [31:16] of the generator before it advances. The target is floor(r * W / 65536), where W is the weight of row `cur_state`. `next_state` is the lowest column whose running total is strictly greater than the target.
- R4: `next_neg` is the stored sign bit of the chosen entry. `next_weight` is the weight of row `next_state`.
- R5: The generator is a 32-bit Galois register that shifts right and XORs in 32'h8020_0003 when the bit shifted out is 1. It advances exactly once per accepted start.
- R6: `seed_we` loads `seed_val` into the generator, with a zero value replaced by 32'h0000_0001. A seed load takes priority over an advance in the same cycle.
- R7: `done` is low in the cycle after an accepted start. If column j is chosen, `done` rises j+1 clock edges after the accepting edge, which is never more than N_STATES edges.
- R8: While `start` stays low, `done` and all results hold their values.
- R9: A `start` that arrives while a scan is in progress is ignored. The scan, its result and the generator are unaffected.
- R10: For a row whose running totals are all zero, the scan runs to the last column. The result is then `next_state` equal to the current state, `next_neg` 0, and `done` after N_STATES edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_row | input | 3 | Row written |
| tbl_col | input | 3 | Column written |
| tbl_cum | input | 16 | Running absolute total for that column |
| tbl_neg | input | 1 | Sign of that entry, 1 = negative |
| seed_we | input | 1 | Load generator seed |
| seed_val | input | 32 | Seed value (zero becomes 1) |
| start | input | 1 | Begin one step |
| cur_state | input | 3 | Current walk state (row to sample) |
| done | output | 1 | Result valid, held until next start |
| next_state | output | 3 | Chosen next state |
| next_neg | output | 1 | Sign of chosen entry |
| next_weight | output | 16 | Weight of row `next_state` |

## Verification
The assertions assume several things about how the block is driven. Each row's running totals never decrease across the columns. Table writes and seed loads never coincide with a scan in progress. `tbl_row` and `tbl_col` stay below N_STATES. The bench keeps to these rules: it fills the whole table with non-decreasing totals before the first step, and it loads seeds only while the block is idle. It also keeps the largest row weight below 65536, so that the target always fits the table width.

// File: rtl/mks_pkg.sv
// Shared definitions for the Markov transition sampler.
// Assumes: nothing beyond IEEE 1800-2017.
package mks_pkg;

    typedef enum logic [1:0] {SC_IDLE, SC_SCAN, SC_HOLD} scan_state_e;

    localparam logic [31:0] LFSR_MASK = 32'h8020_0003;

    // One right shift of the Galois generator.
    function automatic logic [31:0] lfsr_step(input logic [31:0] s);
        return s[0] ? ((s >> 1) ^ LFSR_MASK) : (s >> 1);
    endfunction

endpackage

// File: rtl/mks_lfsr.sv
// 32-bit maximal-length Galois random source. It presents its top RND_W
// bits as the draw and advances once per request. A seed can be loaded.
// Assumes: load and advance come from synchronous logic in the same domain.
module mks_lfsr #(
    parameter logic [31:0] SEED_INIT = 32'h1D87_2B41,
    parameter int          RND_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [31:0]      load_val,
    input  logic             advance,
    output logic [RND_W-1:0] rnd
);
    import mks_pkg::*;

    logic [31:0] state_q;

    // Reset, seed load (zero mapped to 1), or one advance step.
    always_ff @(posedge clk) begin
        if (!rst_n)       state_q <= SEED_INIT;
        else if (load)    state_q <= (load_val == 32'd0) ? 32'd1 : load_val;
        else if (advance) state_q <= lfsr_step(state_q);
    end

    assign rnd = state_q[31 -: RND_W];

    a_r5_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != 32'd0);
    a_r5_moves_on_draw: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load) |=> state_q != $past(state_q));
    a_r6_seed_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != 32'd0) |=> state_q == $past(load_val));

endmodule

// File: rtl/mks_row_table.sv
// Register table of running absolute totals and sign bits, one row per state.
// It has one write port, one entry read port and two row-weight read ports.
// Assumes: write indices below N.
module mks_row_table #(
    parameter int N     = 8,
    parameter int MAG_W = 16,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] w_row,
    input  logic [IDX_W-1:0] w_col,
    input  logic [MAG_W-1:0] w_cum,
    input  logic             w_neg,
    input  logic [IDX_W-1:0] e_row,
    input  logic [IDX_W-1:0] e_col,
    output logic [MAG_W-1:0] e_cum,
    output logic             e_neg,
    input  logic [IDX_W-1:0] wa_row,
    output logic [MAG_W-1:0] wa,
    input  logic [IDX_W-1:0] wb_row,
    output logic [MAG_W-1:0] wb
);
    logic [MAG_W-1:0] cum_q [N][N];
    logic [N-1:0]     neg_q [N];
    logic [MAG_W-1:0] row_wt [N];

    // Clear on reset, otherwise store the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < N; r++) begin
                neg_q[r] <= '0;
                for (int c = 0; c < N; c++) cum_q[r][c] <= '0;
            end
        end else if (we) begin
            cum_q[w_row][w_col] <= w_cum;
            neg_q[w_row][w_col] <= w_neg;
        end
    end

    // The weight of each row is its last running total.
    for (genvar g = 0; g < N; g++) begin : g_wt
        assign row_wt[g] = cum_q[g][N-1];
    end

    assign e_cum = cum_q[e_row][e_col];
    assign e_neg = neg_q[e_row][e_col];
    assign wa    = row_wt[wa_row];
    assign wb    = row_wt[wb_row];

    a_r2_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (int'(w_row) < N && int'(w_col) < N));

endmodule

// File: rtl/mks_scanner.sv
// Start/done sequencer. On an accepted start it latches the row and the
// scaled target, then tests one column per cycle against the target. It
// stops at the first running total above the target, or at the last column.
// Assumes: running totals are non-decreasing and unchanged during a scan.
module mks_scanner #(
    parameter int N     = 8,
    parameter int MAG_W = 16,
    parameter int RND_W = 16,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] cur_state,
    input  logic [RND_W-1:0] rnd,
    input  logic [MAG_W-1:0] row_wt,
    output logic             draw,
    output logic [IDX_W-1:0] e_row,
    output logic [IDX_W-1:0] e_col,
    input  logic [MAG_W-1:0] e_cum,
    input  logic             e_neg,
    output logic [IDX_W-1:0] pick_row,
    input  logic [MAG_W-1:0] pick_wt,
    output logic             done,
    output logic [IDX_W-1:0] next_state,
    output logic             next_neg,
    output logic [MAG_W-1:0] next_weight
);
    import mks_pkg::*;

    localparam int PROD_W = RND_W + MAG_W;

    scan_state_e      state_q;
    logic [IDX_W-1:0] row_q, idx_q;
    logic [MAG_W-1:0] target_q;
    logic [PROD_W-1:0] prod;
    logic             accept, hit, last;

    // Acceptance, scaled target and hit decision for the column under test.
    always_comb begin
        accept   = start && (state_q != SC_SCAN);
        prod     = PROD_W'(rnd) * PROD_W'(row_wt);
        hit      = e_cum > target_q;
        last     = idx_q == IDX_W'(N-1);
        pick_row = hit ? idx_q : row_q;
    end

    assign draw  = accept;
    assign e_row = row_q;
    assign e_col = idx_q;

    // Sequencer: latch on start, step the column, then hold the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= SC_IDLE;
            row_q       <= '0;
            idx_q       <= '0;
            target_q    <= '0;
            done        <= 1'b0;
            next_state  <= '0;
            next_neg    <= 1'b0;
            next_weight <= '0;
        end else if (accept) begin
            state_q  <= SC_SCAN;
            row_q    <= cur_state;
            idx_q    <= '0;
            target_q <= prod[PROD_W-1:RND_W];
            done     <= 1'b0;
        end else if (state_q == SC_SCAN) begin
            if (hit || last) begin
                state_q     <= SC_HOLD;
                done        <= 1'b1;
                next_state  <= pick_row;
                next_neg    <= hit & e_neg;
                next_weight <= pick_wt;
            end else begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    a_r7_start_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !done);
    a_r7_scan_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SC_SCAN && last) |=> state_q != SC_SCAN);
    a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(next_state) && $stable(next_neg)
                              && $stable(next_weight)));
    a_r9_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state_q == SC_SCAN) |=> row_q == $past(row_q));
    a_r10_miss_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SC_SCAN && last && !hit) |=> (next_state == row_q && !next_neg));
    a_r3_state_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> int'(next_state) < N);

endmodule

// File: rtl/markov_step_sampler.sv
// Top level of the Markov transition sampler: row table, random source and
// scanning sequencer. One start yields one sampled transition.
// Assumes: table and seed are written only while no scan is in progress.
module markov_step_sampler #(
    parameter int          N_STATES  = 8,
    parameter int          MAG_W     = 16,
    parameter int          RND_W     = 16,
    parameter logic [31:0] SEED_INIT = 32'h1D87_2B41,
    localparam int         IDX_W     = $clog2(N_STATES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tbl_we,
    input  logic [IDX_W-1:0] tbl_row,
    input  logic [IDX_W-1:0] tbl_col,
    input  logic [MAG_W-1:0] tbl_cum,
    input  logic             tbl_neg,
    input  logic             seed_we,
    input  logic [31:0]      seed_val,
    input  logic             start,
    input  logic [IDX_W-1:0] cur_state,
    output logic             done,
    output logic [IDX_W-1:0] next_state,
    output logic             next_neg,
    output logic [MAG_W-1:0] next_weight
);
    logic [RND_W-1:0] rnd;
    logic             draw;
    logic [IDX_W-1:0] e_row, e_col, pick_row;
    logic [MAG_W-1:0] e_cum, cur_wt, pick_wt;
    logic             e_neg;

    mks_lfsr #(.SEED_INIT(SEED_INIT), .RND_W(RND_W)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .load(seed_we), .load_val(seed_val),
        .advance(draw), .rnd(rnd)
    );

    mks_row_table #(.N(N_STATES), .MAG_W(MAG_W), .IDX_W(IDX_W)) u_table (
        .clk(clk), .rst_n(rst_n), .we(tbl_we), .w_row(tbl_row), .w_col(tbl_col),
        .w_cum(tbl_cum), .w_neg(tbl_neg), .e_row(e_row), .e_col(e_col),
        .e_cum(e_cum), .e_neg(e_neg), .wa_row(cur_state), .wa(cur_wt),
        .wb_row(pick_row), .wb(pick_wt)
    );

    mks_scanner #(.N(N_STATES), .MAG_W(MAG_W), .RND_W(RND_W), .IDX_W(IDX_W)) u_scan (
        .clk(clk), .rst_n(rst_n), .start(start), .cur_state(cur_state),
        .rnd(rnd), .row_wt(cur_wt), .draw(draw), .e_row(e_row), .e_col(e_col),
        .e_cum(e_cum), .e_neg(e_neg), .pick_row(pick_row), .pick_wt(pick_wt),
        .done(done), .next_state(next_state), .next_neg(next_neg),
        .next_weight(next_weight)
    );

endmodule

// File: tb/test_markov_step_sampler.sv
module test_markov_step_sampler;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_we = 1'b0;
    logic [2:0]  tbl_row = '0, tbl_col = '0;
    logic [15:0] tbl_cum = '0;
    logic        tbl_neg = 1'b0;
    logic        seed_we = 1'b0;
    logic [31:0] seed_val = '0;
    logic        start = 1'b0;
    logic [2:0]  cur_state = '0;
    logic        done;
    logic [2:0]  next_state;
    logic        next_neg;
    logic [15:0] next_weight;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    int          cum_m [N][N];
    bit          neg_m [N][N];
    logic [31:0] m_lfsr;

    localparam logic [2:0] VEC_ROW [12] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd6,
                                            3'd7, 3'd7, 3'd2, 3'd0, 3'd6, 3'd4};

    always #10 clk = ~clk;

    markov_step_sampler i_markov_step_sampler (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_row(tbl_row),
        .tbl_col(tbl_col), .tbl_cum(tbl_cum), .tbl_neg(tbl_neg),
        .seed_we(seed_we), .seed_val(seed_val), .start(start),
        .cur_state(cur_state), .done(done), .next_state(next_state),
        .next_neg(next_neg), .next_weight(next_weight)
    );

    function automatic logic [31:0] model_next(input logic [31:0] s);
        logic [31:0] t;
        t = s >> 1;
        if (s[0]) t = t ^ 32'h8020_0003;
        return t;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_seed(input logic [31:0] v);
        @(negedge clk);
        seed_we = 1'b1; seed_val = v;
        @(negedge clk);
        seed_we = 1'b0;
        m_lfsr = (v == 0) ? 32'd1 : v;
    endtask

    // One step: model the draw, run the block, compare every result.
    task automatic do_step(input int row, input bit poke);
        longint r, w, tgt;
        int pick, lat_exp, cnt;
        bit hit;
        r = m_lfsr[31:16];
        w = cum_m[row][N-1];
        tgt = (r * w) >> 16;
        hit = 1'b0; pick = row; lat_exp = N;
        for (int j = 0; j < N; j++) begin
            if (!hit && cum_m[row][j] > tgt) begin
                hit = 1'b1; pick = j; lat_exp = j + 1;
            end
        end
        m_lfsr = model_next(m_lfsr);
        @(negedge clk);
        cur_state = row[2:0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0; cnt = 0;
        chk(done == 1'b0, "R7 done low after start", done, 0);
        if (poke) begin
            cur_state = 3'd5; start = 1'b1;
            @(negedge clk);
            start = 1'b0; cnt++;
        end
        while (!done && cnt < 40) begin
            @(negedge clk);
            cnt++;
        end
        chk(cnt == lat_exp, poke ? "R9 latency with busy start" : "R7 latency", cnt, lat_exp);
        chk(next_state == pick, hit ? "R3 next_state" : "R10 next_state", next_state, pick);
        chk(next_neg == (hit ? neg_m[row][pick] : 1'b0), "R4 next_neg", next_neg,
            hit ? neg_m[row][pick] : 0);
        chk(next_weight == cum_m[pick][N-1], "R4 next_weight", next_weight, cum_m[pick][N-1]);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [2:0] hs;
        logic [15:0] hw;
        logic hn;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(done == 0, "R1 done", done, 0);
        chk(next_state == 0, "R1 next_state", next_state, 0);
        chk(next_neg == 0, "R1 next_neg", next_neg, 0);
        chk(next_weight == 0, "R1 next_weight", next_weight, 0);
        m_lfsr = 32'h1D87_2B41;

        // R2: fill the table with running totals; row 5 stays zero
        for (int i = 0; i < N; i++) begin
            int run;
            run = 0;
            for (int j = 0; j < N; j++) begin
                if (i != 5) run += ((i * 3 + j * 5 + 1) % 7) * ((i == 7) ? 1200 : 37);
                cum_m[i][j] = run;
                neg_m[i][j] = ((i + 2 * j) % 3) == 0;
                @(negedge clk);
                tbl_we = 1'b1; tbl_row = i[2:0]; tbl_col = j[2:0];
                tbl_cum = run[15:0]; tbl_neg = neg_m[i][j];
            end
        end
        @(negedge clk);
        tbl_we = 1'b0;

        // R3 R4 R5: vector walk from the reset seed
        for (int v = 0; v < 12; v++) do_step(VEC_ROW[v], 1'b0);

        // R8: results hold while start stays low
        hs = next_state; hn = next_neg; hw = next_weight;
        repeat (6) @(negedge clk);
        chk(done == 1 && next_state == hs, "R8 held state", next_state, hs);
        chk(next_neg == hn && next_weight == hw, "R8 held sign/weight", next_weight, hw);

        // R6: zero seed becomes 1, draw is 0, first nonzero column is chosen
        load_seed(32'd0);
        do_step(3, 1'b0);
        do_step(7, 1'b0);
        // R6: seed with high draw picks near the row end
        load_seed(32'hFFFF_0000);
        do_step(1, 1'b0);
        do_step(4, 1'b0);

        // R9: a start during a scan is ignored, generator not advanced
        load_seed(32'hFFFF_1234);
        do_step(6, 1'b1);
        do_step(2, 1'b0);

        // R10: all-zero row stays put after a full scan
        do_step(5, 1'b0);
        do_step(5, 1'b1);
        do_step(0, 1'b0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule